// File: doc/BRIEF.md
# Linear CCD Drive Timing Generator

This block produces the digital clocks needed to read a three-colour linear CCD sensor that has a two-phase analog readout register. From one system clock it derives a shift-gate pulse that moves the photodiode charge into the register, two complementary transfer phases, and a reset pulse for every pixel. It also gives a line-active level and a one-cycle pixel-valid strobe for the capture logic further down the chain. Every width and count is a parameter in system-clock cycles. A declared clock period lets the built-in checks convert those counts to nanoseconds.

A line starts with a frozen window made of set-up, shift gate and hold. A readout of a fixed number of transfer periods follows, two pixels per transfer period. Readout keeps running between shift gates, so the register is always flushed. The next shift gate comes at a line boundary. It is caused either by an external trigger or, when the integration setting is non-zero, by a count of completed lines. A trigger that arrives during a line waits for that line to end.

Top module: `ccd_line_timer`

## Requirements
- R1: While reset is held and afterwards until the first trigger, shiftGate, pixReset, lineActive and pixValid are 0, xferPh1 is 1 and xferPh2 is 0.
- R2: From idle, a trigger sampled on a clock edge raises shiftGate SETUP_CYC cycles later, and shiftGate stays high for exactly SG_CYC cycles.
- R3: Both transfer phases are held parked (xferPh1=1, xferPh2=0) through the set-up, shift-gate and hold windows. Phases are static for at least SETUP_CYC cycles before shiftGate rises, and the first phase change (xferPh1 falling) comes exactly HOLD_CYC cycles after shiftGate falls.
- R4: xferPh2 is always the inverse of xferPh1. During readout xferPh1 changes every PIX_CYC cycles, so it runs at half the pixel rate.
- R5: pixReset is high only during readout, for the first RST_CYC cycles of each pixel period of PIX_CYC cycles. The first pulse of a line starts in the same cycle as readout.
- R6: Each line lasts 2*MIN_XFER pixel periods, with lineActive high for all of them, and contains MIN_XFER rising edges of xferPh1. MIN_XFER must exceed 1114, and every pair of shift gates is separated by at least one whole line.
- R7: A trigger taken during a line does not cut it short. The set-up window begins in the cycle after the line's last cycle, so consecutive shift-gate rises are SG_CYC+HOLD_CYC+2*MIN_XFER*PIX_CYC+SETUP_CYC cycles apart.
- R8: With intLines = N > 0, shift gates repeat on their own after every N lines, SG_CYC+HOLD_CYC+N*2*MIN_XFER*PIX_CYC+SETUP_CYC cycles apart.
- R9: With intLines = 0 and no trigger, readout continues line after line with lineActive high and no shift gate.
- R10: pixValid pulses for one cycle in the last cycle of pixel periods VALID_FIRST to VALID_FIRST+VALID_CNT-1 (counted from 0) of the first line after a shift gate only. Its first pulse comes (VALID_FIRST+1)*PIX_CYC-1 cycles after readout starts.
- R11: With a clock period of CLK_NS ns, the shift gate is at least 200 ns wide, the reset pulse is at least 60 ns, reset stays low at least 100 ns before its next rise, and a pixel period is at least 500 ns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lineTrig | input | 1 | Start / line trigger, sampled each clock |
| intLines | input | INT_W | Integration period in lines; 0 selects trigger-only mode |
| shiftGate | output | 1 | Shift-gate pulse |
| xferPh1 | output | 1 | Transfer phase 1 |
| xferPh2 | output | 1 | Transfer phase 2 |
| pixReset | output | 1 | Per-pixel reset pulse |
| lineActive | output | 1 | High during readout |
| pixValid | output | 1 | One-cycle strobe per valid image pixel |

## Verification
The assertions assume that lineTrig is synchronous to clk and that CLK_NS gives the real clock period. The nanosecond minimums are judged against that declared period, and the window counts are taken to be at least one. The bench declares a 100 ns timebase so that short cycle counts still meet the nanosecond limits. It pulses the trigger for one cycle at a time, either from idle or well inside a line. It changes intLines only just after a shift gate has been seen, so each measured interval belongs to one setting.

// File: rtl/ccd_timer_pkg.sv
`timescale 1ns/1ps
package ccd_timer_pkg;

  localparam int XFER_FLOOR  = 1114;
  localparam int SG_MIN_NS   = 200;
  localparam int RST_MIN_NS  = 60;
  localparam int RST_HOLD_NS = 100;
  localparam int PIX_MIN_NS  = 500;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_GATE,
    ST_HOLD,
    ST_READ
  } lineState_t;

  typedef struct packed {
    logic freeze;
    logic sgOn;
    logic readRun;
    logic firstLine;
  } lineStrobe_t;

endpackage

// File: rtl/ccd_timer_ctrl.sv
`timescale 1ns/1ps
module ccd_timer_ctrl
  import ccd_timer_pkg::*;
#(
  parameter int SETUP_CYC = 13,
  parameter int SG_CYC    = 125,
  parameter int HOLD_CYC  = 13,
  parameter int INT_W     = 8,
  parameter int CLK_NS    = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineTrig,
  input  logic [INT_W-1:0] intLines,
  input  logic             lineLast,
  output lineStrobe_t      strb
);

  localparam int SEQ_MAX = (SETUP_CYC > SG_CYC) ?
                           ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC) :
                           ((SG_CYC > HOLD_CYC) ? SG_CYC : HOLD_CYC);
  localparam int CNT_W = $clog2(SEQ_MAX + 1);

  lineState_t       state;
  logic [CNT_W-1:0] seqCnt;
  logic             pending;
  logic             firstLine;
  logic [INT_W-1:0] linesDone;
  logic [INT_W:0]   linesNext;
  logic             startNow;

  assign linesNext = {1'b0, linesDone} + {{INT_W{1'b0}}, 1'b1};
  assign startNow  = lineTrig || pending ||
                     ((intLines != '0) && (linesNext >= {1'b0, intLines}));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      seqCnt    <= '0;
      firstLine <= 1'b0;
      linesDone <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (lineTrig) begin
            state  <= ST_SETUP;
            seqCnt <= '0;
          end
        end
        ST_SETUP: begin
          if (seqCnt == CNT_W'(SETUP_CYC - 1)) begin
            state  <= ST_GATE;
            seqCnt <= '0;
          end else seqCnt <= seqCnt + 1'b1;
        end
        ST_GATE: begin
          if (seqCnt == CNT_W'(SG_CYC - 1)) begin
            state  <= ST_HOLD;
            seqCnt <= '0;
          end else seqCnt <= seqCnt + 1'b1;
        end
        ST_HOLD: begin
          if (seqCnt == CNT_W'(HOLD_CYC - 1)) begin
            state     <= ST_READ;
            seqCnt    <= '0;
            firstLine <= 1'b1;
            linesDone <= '0;
          end else seqCnt <= seqCnt + 1'b1;
        end
        ST_READ: begin
          if (lineLast) begin
            firstLine <= 1'b0;
            if (startNow) begin
              state  <= ST_SETUP;
              seqCnt <= '0;
            end else if (linesDone != '1) begin
              linesDone <= linesDone + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // A trigger seen while busy waits for the next line boundary.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pending <= 1'b0;
    else if (state == ST_READ && lineLast && startNow) pending <= 1'b0;
    else if (lineTrig && state != ST_IDLE) pending <= 1'b1;
  end

  always_comb begin
    strb.freeze    = (state == ST_SETUP) || (state == ST_GATE) || (state == ST_HOLD);
    strb.sgOn      = (state == ST_GATE);
    strb.readRun   = (state == ST_READ);
    strb.firstLine = firstLine;
  end

  // Shift-gate width measured for the nanosecond check.
  logic [15:0] sgRun;
  logic        prevSg;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sgRun  <= '0;
      prevSg <= 1'b0;
    end else begin
      prevSg <= strb.sgOn;
      if (strb.sgOn) sgRun <= prevSg ? sgRun + 1'b1 : 16'd1;
    end
  end

  assert_sg_width_R11: assert property (@(posedge clk) disable iff (!rstN)
    (prevSg && !strb.sgOn) |-> (int'(sgRun) * CLK_NS >= SG_MIN_NS));

  assert_line_holdoff_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.readRun && !lineLast) |=> strb.readRun);

endmodule

// File: rtl/ccd_timer_path.sv
`timescale 1ns/1ps
module ccd_timer_path
  import ccd_timer_pkg::*;
#(
  parameter int PIX_CYC     = 125,
  parameter int RST_CYC     = 32,
  parameter int MIN_XFER    = 1115,
  parameter int VALID_FIRST = 63,
  parameter int VALID_CNT   = 2160,
  parameter int CLK_NS      = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  lineStrobe_t strb,
  output logic        lineLast,
  output logic        phi1,
  output logic        phi2,
  output logic        rstPulse,
  output logic        lineActive,
  output logic        pixValid
);

  localparam int LINE_PIX = 2 * MIN_XFER;
  localparam int IDX_W    = $clog2(LINE_PIX);
  localparam int CYC_W    = (PIX_CYC > 2) ? $clog2(PIX_CYC) : 1;
  localparam logic [IDX_W:0] V_LO = (IDX_W + 1)'(VALID_FIRST);
  localparam logic [IDX_W:0] V_HI = (IDX_W + 1)'(VALID_FIRST + VALID_CNT);

  logic [CYC_W-1:0] pixCyc;
  logic [IDX_W-1:0] pixIdx;
  logic             pixEnd;

  assign pixEnd   = (pixCyc == CYC_W'(PIX_CYC - 1));
  assign lineLast = strb.readRun && pixEnd && (pixIdx == IDX_W'(LINE_PIX - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixCyc <= '0;
      pixIdx <= '0;
    end else if (!strb.readRun) begin
      pixCyc <= '0;
      pixIdx <= '0;
    end else if (pixEnd) begin
      pixCyc <= '0;
      pixIdx <= lineLast ? '0 : pixIdx + 1'b1;
    end else begin
      pixCyc <= pixCyc + 1'b1;
    end
  end

  // Phase 1 follows the odd pixels, so it runs at half the pixel rate.
  assign phi1       = strb.readRun ? pixIdx[0]  : 1'b1;
  assign phi2       = strb.readRun ? ~pixIdx[0] : 1'b0;
  assign rstPulse   = strb.readRun && (pixCyc < CYC_W'(RST_CYC));
  assign lineActive = strb.readRun;
  assign pixValid   = strb.readRun && strb.firstLine && pixEnd &&
                      ({1'b0, pixIdx} >= V_LO) && ({1'b0, pixIdx} < V_HI);

  // Run-length and transfer counters feeding the checks below.
  logic [15:0] rstHigh, rstLow, xferCnt;
  logic        prevRst, prevSg, prevFreeze, seenGate;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstHigh    <= '0;
      rstLow     <= '1;
      xferCnt    <= '0;
      prevRst    <= 1'b0;
      prevSg     <= 1'b0;
      prevFreeze <= 1'b0;
      seenGate   <= 1'b0;
    end else begin
      prevRst    <= rstPulse;
      prevSg     <= strb.sgOn;
      prevFreeze <= strb.freeze;
      if (rstPulse) rstHigh <= prevRst ? rstHigh + 1'b1 : 16'd1;
      else if (!prevRst) rstLow <= (rstLow == '1) ? rstLow : rstLow + 1'b1;
      else rstLow <= 16'd1;
      if (strb.sgOn && !prevSg) begin
        xferCnt  <= '0;
        seenGate <= 1'b1;
      end else if (strb.readRun && pixEnd && pixIdx[0] && xferCnt != '1) begin
        xferCnt <= xferCnt + 1'b1;
      end
    end
  end

  assert_phase_complement_R4: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |-> (phi1 ^ phi2));

  assert_phase_frozen_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.freeze && prevFreeze) |-> ($stable(phi1) && $stable(phi2)));

  assert_reset_width_R11: assert property (@(posedge clk) disable iff (!rstN)
    (prevRst && !rstPulse) |-> (int'(rstHigh) * CLK_NS >= RST_MIN_NS));

  assert_reset_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!prevRst && rstPulse) |-> (int'(rstLow) * CLK_NS >= RST_HOLD_NS));

  assert_pixel_rate_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!prevRst && rstPulse && rstHigh != '0) |->
      ((int'(rstLow) + int'(rstHigh)) * CLK_NS >= PIX_MIN_NS));

  assert_reset_in_read_R5: assert property (@(posedge clk) disable iff (!rstN)
    rstPulse |-> strb.readRun);

  assert_xfer_count_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.sgOn && !prevSg && seenGate) |-> (int'(xferCnt) > XFER_FLOOR));

endmodule

// File: rtl/ccd_line_timer.sv
`timescale 1ns/1ps
module ccd_line_timer
  import ccd_timer_pkg::*;
#(
  parameter int CLK_NS      = 8,
  parameter int PIX_CYC     = 125,
  parameter int RST_CYC     = 32,
  parameter int SG_CYC      = 125,
  parameter int SETUP_CYC   = 13,
  parameter int HOLD_CYC    = 13,
  parameter int MIN_XFER    = 1115,
  parameter int VALID_FIRST = 63,
  parameter int VALID_CNT   = 2160,
  parameter int INT_W       = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineTrig,
  input  logic [INT_W-1:0] intLines,
  output logic             shiftGate,
  output logic             xferPh1,
  output logic             xferPh2,
  output logic             pixReset,
  output logic             lineActive,
  output logic             pixValid
);

  lineStrobe_t strb;
  logic        lineLast;

  ccd_timer_ctrl #(
    .SETUP_CYC(SETUP_CYC), .SG_CYC(SG_CYC), .HOLD_CYC(HOLD_CYC),
    .INT_W(INT_W), .CLK_NS(CLK_NS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .lineTrig(lineTrig), .intLines(intLines),
    .lineLast(lineLast), .strb(strb)
  );

  ccd_timer_path #(
    .PIX_CYC(PIX_CYC), .RST_CYC(RST_CYC), .MIN_XFER(MIN_XFER),
    .VALID_FIRST(VALID_FIRST), .VALID_CNT(VALID_CNT), .CLK_NS(CLK_NS)
  ) u_path (
    .clk(clk), .rstN(rstN), .strb(strb), .lineLast(lineLast),
    .phi1(xferPh1), .phi2(xferPh2), .rstPulse(pixReset),
    .lineActive(lineActive), .pixValid(pixValid)
  );

  assign shiftGate = strb.sgOn;

endmodule

// File: tb/ccd_line_timer_test.sv
`timescale 1ns/1ps
module ccd_line_timer_test;

  localparam int CLK_NS      = 100;
  localparam int PIX_CYC     = 5;
  localparam int RST_CYC     = 1;
  localparam int SG_CYC      = 3;
  localparam int SETUP_CYC   = 2;
  localparam int HOLD_CYC    = 2;
  localparam int MIN_XFER    = 1115;
  localparam int VALID_FIRST = 63;
  localparam int VALID_CNT   = 2160;
  localparam int INT_W       = 8;
  localparam int LINE_CYC    = 2 * MIN_XFER * PIX_CYC;
  localparam int FRAME_FIX   = SG_CYC + HOLD_CYC + SETUP_CYC;
  localparam int HOLD_MIN    = (100 + CLK_NS - 1) / CLK_NS;
  localparam int WATCHDOG    = 180000;

  localparam int TBL_N = 2;
  localparam int tblLines [TBL_N] = '{1, 2};
  localparam int tblGap   [TBL_N] = '{FRAME_FIX + LINE_CYC, FRAME_FIX + 2 * LINE_CYC};
  localparam int tblXfer  [TBL_N] = '{MIN_XFER, 2 * MIN_XFER};

  logic clk, rstN, lineTrig;
  logic [INT_W-1:0] intLines;
  logic shiftGate, xferPh1, xferPh2, pixReset, lineActive, pixValid;

  ccd_line_timer #(
    .CLK_NS(CLK_NS), .PIX_CYC(PIX_CYC), .RST_CYC(RST_CYC), .SG_CYC(SG_CYC),
    .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC), .MIN_XFER(MIN_XFER),
    .VALID_FIRST(VALID_FIRST), .VALID_CNT(VALID_CNT), .INT_W(INT_W)
  ) uut (
    .clk(clk), .rstN(rstN), .lineTrig(lineTrig), .intLines(intLines),
    .shiftGate(shiftGate), .xferPh1(xferPh1), .xferPh2(xferPh2),
    .pixReset(pixReset), .lineActive(lineActive), .pixValid(pixValid)
  );

  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  int testCount = 0;
  int failCount = 0;
  bit finished  = 1'b0;

  task automatic chk(input string req, input int actual, input int expected);
    testCount++;
    if (actual != expected) begin
      failCount++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic chkGe(input string req, input int actual, input int floorVal);
    testCount++;
    if (actual < floorVal) begin
      failCount++;
      $display("FAIL %s: actual %0d expected at least %0d", req, actual, floorVal);
    end
  endtask

  // Negedge monitor: measures edges and intervals on the ports.
  int cyc = 0;
  int sgCount = 0, sgRiseT = 0, sgFallT = 0, lastInterval = 0, lastSgWidth = 0;
  int setupMeas = 0, holdMeas = -1, lastPhT = 0;
  int xferCnt = 0, lastXfer = 0, laCnt = 0, lastLa = 0, pvCnt = 0, lastPv = 0;
  int rstRiseT = 0, rstFallT = 0, readStartT = 0, pvDelay = -1;
  int phaseEqErr = 0, phHalfBad = 0, rstWidthBad = 0, rstPeriodBad = 0;
  int rstOutside = 0, rstRises = 0, minLow = 1000000;
  bit awaitHold = 0, awaitRead = 0, pvFirstPending = 0;
  logic pSg = 1'b0, pPh1 = 1'b1, pRst = 1'b0, pLa = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (xferPh1 == xferPh2) phaseEqErr++;
    if (pixReset && !lineActive) rstOutside++;
    if (shiftGate && !pSg) begin
      sgCount++;
      lastInterval = cyc - sgRiseT;
      sgRiseT   = cyc;
      setupMeas = cyc - lastPhT;
      lastXfer = xferCnt; xferCnt = 0;
      lastLa   = laCnt;   laCnt   = 0;
      lastPv   = pvCnt;   pvCnt   = 0;
    end
    if (!shiftGate && pSg) begin
      lastSgWidth = cyc - sgRiseT;
      sgFallT   = cyc;
      awaitHold = 1'b1;
      awaitRead = 1'b1;
    end
    if (xferPh1 != pPh1) begin
      if (awaitHold) begin
        holdMeas  = cyc - sgFallT;
        awaitHold = 1'b0;
      end
      if (lineActive && pLa && (cyc - lastPhT) != PIX_CYC) phHalfBad++;
      lastPhT = cyc;
      if (xferPh1) xferCnt++;
    end
    if (pixReset && !pRst) begin
      rstRises++;
      if (awaitRead) begin
        readStartT     = cyc;
        awaitRead      = 1'b0;
        pvFirstPending = 1'b1;
      end
      if (pLa) begin
        if (cyc - rstRiseT != PIX_CYC) rstPeriodBad++;
        if (cyc - rstFallT < minLow) minLow = cyc - rstFallT;
      end
      rstRiseT = cyc;
    end
    if (!pixReset && pRst) begin
      if (cyc - rstRiseT != RST_CYC) rstWidthBad++;
      rstFallT = cyc;
    end
    if (lineActive) laCnt++;
    if (pixValid) begin
      pvCnt++;
      if (pvFirstPending) begin
        pvDelay        = cyc - readStartT;
        pvFirstPending = 1'b0;
      end
    end
    pSg = shiftGate; pPh1 = xferPh1; pRst = pixReset; pLa = lineActive;
  end

  task automatic waitSg(input int target);
    while (sgCount < target) @(negedge clk);
  endtask

  initial begin
    rstN = 1'b0; lineTrig = 1'b0; intLines = '0;
    repeat (4) @(negedge clk);
    // R1: outputs while reset is held
    chk("R1 in reset", {shiftGate, xferPh1, xferPh2, pixReset, lineActive, pixValid}, 6'b010000);
    rstN = 1'b1;
    repeat (20) @(negedge clk);
    chk("R1 idle outputs", {shiftGate, xferPh1, xferPh2, pixReset, lineActive, pixValid}, 6'b010000);
    chk("R1 no activity", sgCount + rstRises, 0);

    // R2: start from idle
    begin
      int k = 0;
      lineTrig = 1'b1;
      while (!shiftGate && k < 100) begin
        @(negedge clk);
        k++;
        if (k == 1) lineTrig = 1'b0;
      end
      chk("R2 start delay", k, SETUP_CYC + 1);
    end
    while (shiftGate) @(negedge clk);
    repeat (HOLD_CYC + 20) @(negedge clk);
    chk("R2 gate width", lastSgWidth, SG_CYC);
    chk("R3 hold before first phase change", holdMeas, HOLD_CYC);
    chkGe("R3 setup before gate", setupMeas, SETUP_CYC);

    // R7: trigger mid-line is held off
    repeat (1000) @(negedge clk);
    lineTrig = 1'b1;
    @(negedge clk);
    lineTrig = 1'b0;
    waitSg(2);
    chk("R7 gate spacing after held trigger", lastInterval, FRAME_FIX + LINE_CYC);
    chk("R6 transfer periods per line", lastXfer, MIN_XFER);
    chk("R6 lineActive cycles per line", lastLa, LINE_CYC);
    chk("R10 valid pixels in first line", lastPv, VALID_CNT);
    chk("R10 first valid pixel offset", pvDelay, (VALID_FIRST + 1) * PIX_CYC - 1);
    chkGe("R3 setup after a line", setupMeas, SETUP_CYC);

    // R9: free-running readout without a trigger
    repeat (FRAME_FIX + LINE_CYC + 20) @(negedge clk);
    chk("R9 no gate without trigger", sgCount, 2);
    chk("R9 readout continues", int'(lineActive), 1);
    repeat (LINE_CYC) @(negedge clk);
    chk("R10 no valid pixels in later line", pvCnt, VALID_CNT);

    // R8: automatic repeat, table walk
    intLines = INT_W'(1);
    waitSg(3);
    for (int i = 0; i < TBL_N; i++) begin
      int base;
      base = sgCount;
      intLines = INT_W'(tblLines[i]);
      waitSg(base + 1);
      chk($sformatf("R8 gate spacing N=%0d", tblLines[i]), lastInterval, tblGap[i]);
      chk($sformatf("R6 transfers N=%0d", tblLines[i]), lastXfer, tblXfer[i]);
    end

    // Whole-run edge statistics
    chk("R4 phases complementary", phaseEqErr, 0);
    chk("R4 phase half period", phHalfBad, 0);
    chk("R5 reset width", rstWidthBad, 0);
    chk("R5 reset period", rstPeriodBad, 0);
    chk("R5 reset only in readout", rstOutside, 0);
    chkGe("R11 reset low time", minLow, HOLD_MIN);
    chkGe("R11 gate width in ns", lastSgWidth * CLK_NS, 200);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    while (cyc < WATCHDOG) @(negedge clk);
    if (!finished) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

endmodule